// File: doc/BRIEF.md
# Framed Macroblock Input Receiver

This block takes a picture that arrives one byte at a time as CIF or QCIF macroblocks and writes it into an external frame store as 16-bit words. A byte counts only in a clock cycle where the input strobe is high. A frame-sync input wraps the whole picture. Its rising edge starts a frame. The level must then stay high until the last macroblock of that picture has arrived. Internal counters track bytes within a macroblock and macroblocks within the frame. The expected macroblock total comes from a mode input, which is sampled when the frame starts.

The frame store holds more than one picture and is addressed as a ring of words. Each new frame is written just past the end of the last frame that was accepted. If sync drops early, the partial picture is abandoned. The next frame then reuses the same space, and the picture on display does not change. An accepted frame produces a one-cycle completion pulse and raises a pending-swap flag. The display base address moves to the new frame only when the display side signals the end of a field. Packed words wait in a small buffer. They are drained on a fixed schedule of one word per write slot, which gives four words in every 32-clock window with the default parameters.

The control state machine has three states. IDLE waits for a sync rise. RECV counts bytes. DONE holds after a complete frame until sync falls. The transitions are START (IDLE to RECV on a sync rise), COMPLETE (RECV to DONE on the final byte), ABORT (RECV to IDLE when sync is low) and RELEASE (DONE to IDLE when sync is low). Upstream must keep strobes at least four clocks apart.

Top module: `mb_frame_rx`

## Requirements
- R1: While reset is held, and straight after it, `mem_we`, `frame_done` and `swap_pending` are 0 and `disp_base` is 0.
- R2: The bytes accepted in a frame are paired in arrival order. The first byte of each pair goes in bits 7:0 and the second in bits 15:8. Each pair is written exactly once, in order, to consecutive word addresses.
- R3: A rising edge on `fsync` starts a frame. The first frame after reset is written from address 0. Each later frame starts at the address that follows the last word of the most recent accepted frame, so a frame after a dropped one reuses the dropped frame's start address.
- R4: A frame completes when `fsync` is still high on the byte that ends the expected count. That count is CIF_MBS×MB_BYTES bytes when `qcif_mode` was 0 at the frame's start, and QCIF_MBS×MB_BYTES bytes when it was 1. A change of `qcif_mode` during the frame has no effect. Completion gives exactly one `frame_done` pulse, one cycle wide.
- R5: If `fsync` falls before the count completes, there is no `frame_done`, `swap_pending` does not change, and `disp_base` does not change.
- R6: Strobes produce no writes while no frame is open, or after a frame has completed and before the next rise of `fsync`.
- R7: `swap_pending` rises together with `frame_done`. `disp_base` changes only in the cycle after a `field_end` pulse that found `swap_pending` high. It then takes the base of the accepted frame and `swap_pending` clears. A `field_end` with nothing pending changes nothing.
- R8: If two frames complete before a field end, the display switches to the later one.
- R9: Memory writes are at least SLOT_PERIOD = WINDOW_CLKS/WINDOW_WORDS clocks apart, which is 8 clocks with the defaults.
- R10: Write addresses wrap modulo 2^ADDR_W, so a frame that runs past the top of the store continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync: the rise starts a frame; must stay high until the frame ends |
| in_strobe | input | 1 | High for one cycle when `in_byte` is valid |
| in_byte | input | 8 | Incoming macroblock byte |
| qcif_mode | input | 1 | 1 selects the QCIF macroblock count, 0 selects CIF; sampled at frame start |
| field_end | input | 1 | One-cycle pulse at the end of each display field |
| mem_we | output | 1 | Frame-store write strobe |
| mem_addr | output | ADDR_W | Frame-store word address |
| mem_wdata | output | 16 | Frame-store write word |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| swap_pending | output | 1 | A completed frame is waiting for the next field end |
| disp_base | output | ADDR_W | Start address of the frame being displayed |

## Verification
The bench aborts a frame partway through and then sends a fresh one. A design that kept the aborted frame would announce it or move the display. A design that did not rewind the write pointer would place the next frame at the wrong addresses. The bench also sends bytes after a frame has completed and while sync is low. A design that kept counting in those states would emit stray writes. One frame wraps past the top of the store, and one changes the mode input mid-frame, which a design that did not latch the mode would cut short. The bench also completes two frames before a single field end, and pulses a field end with nothing pending, to expose a swap that is taken too early, too late or from the wrong frame.

// File: rtl/mb_rx_pkg.sv
package mb_rx_pkg;

    // Control states of the frame receiver
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a frame-sync rise
        ST_RECV = 2'd1,   // counting bytes of an open frame
        ST_DONE = 2'd2    // frame complete, waiting for sync to drop
    } rx_state_e;

endpackage

// File: rtl/mb_rx_ctrl.sv
module mb_rx_ctrl
    import mb_rx_pkg::*;
#(
    parameter int MB_BYTES = 384,
    parameter int CIF_MBS  = 396,
    parameter int QCIF_MBS = 99,
    parameter int ADDR_W   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              strobe,
    input  logic              qcif_mode,
    output logic              take,
    output logic              start,
    output logic              accept,
    output logic              frame_done,
    output logic [ADDR_W-1:0] base_o
);
    localparam int MAX_MBS = (CIF_MBS > QCIF_MBS) ? CIF_MBS : QCIF_MBS;
    localparam int BYTE_W  = $clog2(MB_BYTES);
    localparam int MB_W    = $clog2(MAX_MBS);
    localparam logic [BYTE_W-1:0] LAST_BYTE  = BYTE_W'(MB_BYTES - 1);
    localparam logic [MB_W-1:0]   CIF_LAST   = MB_W'(CIF_MBS - 1);
    localparam logic [MB_W-1:0]   QCIF_LAST  = MB_W'(QCIF_MBS - 1);
    localparam logic [ADDR_W-1:0] CIF_WORDS  = ADDR_W'(CIF_MBS * MB_BYTES / 2);
    localparam logic [ADDR_W-1:0] QCIF_WORDS = ADDR_W'(QCIF_MBS * MB_BYTES / 2);

    rx_state_e         state_q, state_d;
    logic              fsync_q;
    logic              qcif_q;
    logic [BYTE_W-1:0] byte_cnt_q;
    logic [MB_W-1:0]   mb_cnt_q;
    logic [ADDR_W-1:0] base_q;
    logic              rise, byte_last, mb_last;

    // Next-state and decode logic
    always_comb begin
        rise      = fsync & ~fsync_q;
        take      = (state_q == ST_RECV) && fsync && strobe;
        byte_last = (byte_cnt_q == LAST_BYTE);
        mb_last   = (mb_cnt_q == (qcif_q ? QCIF_LAST : CIF_LAST));
        accept    = take && byte_last && mb_last;
        start     = (state_q == ST_IDLE) && rise;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: if (rise)        state_d = ST_RECV;  // START
            ST_RECV: if (!fsync)      state_d = ST_IDLE;  // ABORT
                     else if (accept) state_d = ST_DONE;  // COMPLETE
            ST_DONE: if (!fsync)      state_d = ST_IDLE;  // RELEASE
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q    <= 1'b1;
            qcif_q     <= 1'b0;
            byte_cnt_q <= '0;
            mb_cnt_q   <= '0;
            base_q     <= '0;
            frame_done <= 1'b0;
        end else begin
            fsync_q    <= fsync;
            frame_done <= accept;
            if (start) begin
                byte_cnt_q <= '0;
                mb_cnt_q   <= '0;
                qcif_q     <= qcif_mode;
            end else if (take) begin
                if (byte_last) begin
                    byte_cnt_q <= '0;
                    mb_cnt_q   <= mb_cnt_q + 1'b1;
                end else begin
                    byte_cnt_q <= byte_cnt_q + 1'b1;
                end
            end
            if (accept)
                base_q <= base_q + (qcif_q ? QCIF_WORDS : CIF_WORDS);
        end
    end

    assign base_o = base_q;

endmodule

// File: rtl/mb_rx_packer.sv
module mb_rx_packer #(
    parameter int ADDR_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_base,
    input  logic               take,
    input  logic [7:0]         data,
    output logic               word_vld,
    output logic [ADDR_W+15:0] word_o
);
    logic              have_low;
    logic [7:0]        low_byte;
    logic [ADDR_W-1:0] wr_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_low <= 1'b0;
            low_byte <= '0;
            wr_ptr   <= '0;
            word_vld <= 1'b0;
            word_o   <= '0;
        end else begin
            word_vld <= 1'b0;
            if (start) begin
                have_low <= 1'b0;
                wr_ptr   <= start_base;
            end else if (take) begin
                if (have_low) begin
                    word_vld <= 1'b1;
                    word_o   <= {wr_ptr, data, low_byte};
                    wr_ptr   <= wr_ptr + 1'b1;
                    have_low <= 1'b0;
                end else begin
                    low_byte <= data;
                    have_low <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mb_rx_wrbuf.sv
module mb_rx_wrbuf #(
    parameter int W           = 34,
    parameter int DEPTH       = 4,
    parameter int SLOT_PERIOD = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    output logic         we,
    output logic [W-1:0] word_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int SW = $clog2(SLOT_PERIOD);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_PERIOD - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW:0]   wr_ptr, rd_ptr;
    logic [SW-1:0] slot;
    logic          empty, full, pop;

    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
        pop   = !empty && (slot == '0);
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr[PW-1:0]] <= push_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            slot   <= '0;
            we     <= 1'b0;
            word_o <= '0;
        end else begin
            slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
            we   <= pop;
            if (pop) begin
                word_o <= mem[rd_ptr[PW-1:0]];
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/mb_rx_swap.sv
module mb_rx_swap #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] accept_base,
    input  logic              field_end,
    output logic              swap_pending,
    output logic [ADDR_W-1:0] disp_base
);
    logic [ADDR_W-1:0] pend_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swap_pending <= 1'b0;
            pend_base    <= '0;
            disp_base    <= '0;
        end else begin
            if (field_end && swap_pending) begin
                disp_base    <= pend_base;
                swap_pending <= 1'b0;
            end
            if (accept) begin
                pend_base    <= accept_base;
                swap_pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mb_frame_rx.sv
module mb_frame_rx #(
    parameter int MB_BYTES     = 384,
    parameter int CIF_MBS      = 396,
    parameter int QCIF_MBS     = 99,
    parameter int ADDR_W       = 18,
    parameter int WINDOW_CLKS  = 32,
    parameter int WINDOW_WORDS = 4,
    parameter int BUF_DEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              in_strobe,
    input  logic [7:0]        in_byte,
    input  logic              qcif_mode,
    input  logic              field_end,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              frame_done,
    output logic              swap_pending,
    output logic [ADDR_W-1:0] disp_base
);
    localparam int SLOT_PERIOD = WINDOW_CLKS / WINDOW_WORDS;
    localparam int WORD_W      = ADDR_W + 16;

    logic              take, start, frame_accept;
    logic [ADDR_W-1:0] frame_base;
    logic              word_vld;
    logic [WORD_W-1:0] packed_word, out_word;

    mb_rx_ctrl #(
        .MB_BYTES(MB_BYTES), .CIF_MBS(CIF_MBS),
        .QCIF_MBS(QCIF_MBS), .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .strobe(in_strobe),
        .qcif_mode(qcif_mode), .take(take), .start(start),
        .accept(frame_accept), .frame_done(frame_done), .base_o(frame_base)
    );

    mb_rx_packer #(.ADDR_W(ADDR_W)) u_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_base(frame_base),
        .take(take), .data(in_byte), .word_vld(word_vld), .word_o(packed_word)
    );

    mb_rx_wrbuf #(.W(WORD_W), .DEPTH(BUF_DEPTH), .SLOT_PERIOD(SLOT_PERIOD)) u_wrbuf (
        .clk(clk), .rst_n(rst_n), .push(word_vld), .push_word(packed_word),
        .we(mem_we), .word_o(out_word)
    );

    mb_rx_swap #(.ADDR_W(ADDR_W)) u_swap (
        .clk(clk), .rst_n(rst_n), .accept(frame_accept), .accept_base(frame_base),
        .field_end(field_end), .swap_pending(swap_pending), .disp_base(disp_base)
    );

    assign mem_addr  = out_word[WORD_W-1:16];
    assign mem_wdata = out_word[15:0];

endmodule

// File: rtl/mb_frame_rx_chk.sv
module mb_frame_rx_chk #(
    parameter int ADDR_W      = 18,
    parameter int SLOT_PERIOD = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsync,
    input logic              field_end,
    input logic              frame_accept,
    input logic              frame_done,
    input logic              swap_pending,
    input logic              mem_we,
    input logic [ADDR_W-1:0] disp_base
);
    logic [15:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           gap <= 16'(SLOT_PERIOD);
        else if (mem_we)      gap <= '0;
        else if (gap != '1)   gap <= gap + 1'b1;
    end

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_done_needs_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(fsync));

    p_done_sets_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> swap_pending);

    p_disp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !field_end |=> $stable(disp_base));

    p_swap_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && swap_pending && !frame_accept) |=> !swap_pending);

    p_write_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (gap >= 16'(SLOT_PERIOD - 1)));

endmodule

bind mb_frame_rx mb_frame_rx_chk #(
    .ADDR_W(ADDR_W), .SLOT_PERIOD(WINDOW_CLKS / WINDOW_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .field_end(field_end),
    .frame_accept(frame_accept), .frame_done(frame_done),
    .swap_pending(swap_pending), .mem_we(mem_we), .disp_base(disp_base)
);

// File: tb/mb_frame_rx_bench.sv
module mb_frame_rx_bench;
    localparam int AW = 6, MBB = 8, CM = 6, QM = 3, SLOT = 8;
    localparam int CIF_BYTES = CM * MBB, QCIF_BYTES = QM * MBB;

    logic clk = 0, rst_n = 0, fsync = 0, in_strobe = 0, qcif_mode = 0, field_end = 0;
    logic [7:0] in_byte = 0;
    logic mem_we, frame_done, swap_pending;
    logic [AW-1:0] mem_addr, disp_base;
    logic [15:0] mem_wdata;

    mb_frame_rx #(.MB_BYTES(MBB), .CIF_MBS(CM), .QCIF_MBS(QM), .ADDR_W(AW)) u_mb_frame_rx (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .in_strobe(in_strobe), .in_byte(in_byte),
        .qcif_mode(qcif_mode), .field_end(field_end), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .frame_done(frame_done), .swap_pending(swap_pending),
        .disp_base(disp_base)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, done_seen = 0, cyc = 0, last_we = -100, salt = 0;
    logic [AW+15:0] exp_q[$];
    logic [AW+15:0] item;
    logic [AW-1:0] m_base = 0, m_disp = 0, m_pend = 0;
    bit m_pending = 0;
    int m_done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_done) done_seen++;
            if (mem_we) begin
                chk(cyc - last_we >= SLOT, "R9 write spacing", cyc - last_we, SLOT);
                last_we = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected write at address", int'(mem_addr), -1);
                end else begin
                    item = exp_q.pop_front();
                    chk(mem_addr == item[AW+15:16], "R3 R10 write address",
                        int'(mem_addr), int'(item[AW+15:16]));
                    chk(mem_wdata == item[15:0], "R2 packed word",
                        int'(mem_wdata), int'(item[15:0]));
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_byte = b; in_strobe = 1; tick(1);
        in_strobe = 0; tick(3);
    endtask

    // Driver: sends nbytes in one frame and pushes expected words
    task automatic run_frame(input int nbytes, input bit qcif, input bit flip);
        int full;
        bit complete;
        logic [AW-1:0] ptr;
        logic [7:0] lo, b;
        full = qcif ? QCIF_BYTES : CIF_BYTES;
        complete = (nbytes >= full);
        ptr = m_base; lo = 0;
        salt++;
        qcif_mode = qcif; fsync = 1; tick(2);
        if (flip) qcif_mode = ~qcif;
        for (int i = 0; i < nbytes; i++) begin
            b = 8'(i * 29 + salt * 53 + 7);
            if (i < full) begin
                if (i % 2 == 0) lo = b;
                else begin exp_q.push_back({ptr, b, lo}); ptr++; end
            end
            send_byte(b);
        end
        tick(40);
        fsync = 0; tick(4);
        if (complete) begin
            m_done++; m_pend = m_base; m_pending = 1;
            m_base = m_base + AW'(full / 2);
        end
        chk(done_seen == m_done, complete ? "R4 frame_done count" : "R5 no frame_done on abort",
            done_seen, m_done);
        chk(swap_pending == m_pending, "R7 pending flag", swap_pending, m_pending);
        chk(disp_base == m_disp, "R7 display held until field end", int'(disp_base), int'(m_disp));
    endtask

    task automatic pulse_field_end();
        field_end = 1; tick(1); field_end = 0; tick(2);
        if (m_pending) begin m_disp = m_pend; m_pending = 0; end
        chk(disp_base == m_disp, "R7 R8 display base after field end", int'(disp_base), int'(m_disp));
        chk(swap_pending == m_pending, "R7 pending after field end", swap_pending, m_pending);
    endtask

    initial begin
        // R1 reset state
        tick(3);
        chk(mem_we == 0, "R1 mem_we in reset", mem_we, 0);
        chk(frame_done == 0, "R1 frame_done in reset", frame_done, 0);
        chk(swap_pending == 0, "R1 swap_pending in reset", swap_pending, 0);
        chk(disp_base == 0, "R1 disp_base in reset", int'(disp_base), 0);
        rst_n = 1; tick(3);
        chk(mem_we == 0 && frame_done == 0 && swap_pending == 0, "R1 after reset",
            mem_we + frame_done + swap_pending, 0);
        run_frame(CIF_BYTES, 0, 0);            // base 0
        pulse_field_end();
        run_frame(QCIF_BYTES, 1, 0);           // base 24
        pulse_field_end();
        run_frame(20, 0, 0);                   // R5 aborted at base 36
        run_frame(CIF_BYTES + 6, 0, 0);        // R3 reuses 36, R6 extra bytes ignored
        pulse_field_end();
        run_frame(CIF_BYTES, 0, 0);            // R10 wraps from 60
        run_frame(QCIF_BYTES, 1, 1);           // R4 mode latched, R8 later frame wins
        pulse_field_end();
        pulse_field_end();                     // R7 nothing pending
        fsync = 0;                             // R6 strobes with no frame open
        for (int i = 0; i < 4; i++) send_byte(8'hA5);
        tick(60);
        chk(exp_q.size() == 0, "R2 all expected words written", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule